// File: doc/BRIEF.md
# Packed-Lane Word ALU

This block is the combinational arithmetic and logic unit of a small 32-bit processor. It handles ordinary word operations, and it also handles packed-byte operations that split each 32-bit operand into four independent 8-bit lanes. Lane 0 occupies bits 7:0 and lane 3 occupies bits 31:24. An operation code selects the function. A lane index selects a byte for the pack and unpack operations. The result appears on the output in the same cycle, with no register in the path.

Word addition, packed addition, word negation and packed negation all use one 32-bit adder. For the packed forms, the top bit of every lane is cleared on both adder inputs. The adder then runs once. After the add, each lane's top bit is rebuilt with an exclusive-or of the two original top bits. Because those top bits never enter the adder, no carry can pass from one lane into the next.

The block is meant to be verified on its own and then placed in a processor datapath. Any operation that takes a single source reads it from operand `a_i`.

Top module: `swar_alu`

## Requirements
- R1: Code 0 returns `a_i & b_i`, code 1 returns `a_i | b_i`, and code 2 returns `a_i ^ b_i`.
- R2: Code 4 returns `a_i + b_i` modulo 2^32. The carry out is dropped.
- R3: Code 5 returns four lane sums. Lane k of the result (bits 8k+7:8k) equals lane k of `a_i` plus lane k of `b_i`, modulo 256. A carry out of one lane never reaches the next lane.
- R4: Code 12 returns the two's complement negation of `a_i` over the whole word, which is `0 - a_i` modulo 2^32.
- R5: Code 13 negates each 8-bit lane of `a_i` on its own, modulo 256.
- R6: Code 10 returns 1 when `a_i` is nonzero and 0 otherwise. Code 11 returns, in each lane, 0x01 when that byte of `a_i` is nonzero and 0x00 when it is zero.
- R7: Code 7 shifts `a_i` by the signed two's complement amount held in `b_i[7:0]`. Bits 31:8 of `b_i` are ignored. A positive amount shifts left, a negative amount shifts logically right, and an amount of magnitude 32 or more gives 0.
- R8: Code 9 returns byte `lane_i mod 4` of `a_i`, zero-extended to 32 bits.
- R9: Code 8 returns `b_i` with byte `lane_i mod 4` replaced by `a_i[7:0]`. The other three bytes pass through unchanged.
- R10: The unused codes 3, 6, 14 and 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand; the source for single-operand operations |
| b_i | input | 32 | Second operand; the shift amount; the destination word for pack |
| lane_i | input | 4 | Lane index; only its low two bits are used |
| result_o | output | 32 | Result |

## Verification
Immediate assertions hold on every evaluation. They check the following:
- Each lane of the shared adder's packed sum matches an independent 8-bit lane sum.
- A word negation added back to its operand gives zero.
- The any result is always 0 or 1, and it is nonzero exactly when the operand is.
- A shift by zero returns the operand unchanged.
- Unpack fills the upper three bytes with zero.
- Pack leaves the unselected lanes equal to the destination word.

Some behaviour needs the bench's chosen stimulus instead:
- All-0xFF lanes plus 0x01, which is the case that shows no carry crosses a lane boundary.
- Shift amounts at and beyond ±32, including −128.
- Lane indices above 3.
- The unused operation codes.

// File: rtl/swar_alu_pkg.sv
package swar_alu_pkg;

    localparam int LANE_W  = 8;
    localparam int LANES   = 4;
    localparam int DATA_W  = LANE_W * LANES;
    localparam int OP_W    = 4;
    localparam int LIDX_W  = 4;
    localparam int LSEL_W  = $clog2(LANES);

    typedef enum logic [OP_W-1:0] {
        OP_AND    = 4'd0,
        OP_OR     = 4'd1,
        OP_XOR    = 4'd2,
        OP_ADD    = 4'd4,
        OP_ADDV   = 4'd5,
        OP_SHIFT  = 4'd7,
        OP_PACK   = 4'd8,
        OP_UNPACK = 4'd9,
        OP_ANY    = 4'd10,
        OP_ANYV   = 4'd11,
        OP_NEG    = 4'd12,
        OP_NEGV   = 4'd13
    } alu_op_e;

    // Word with only the top bit of each lane set.
    function automatic logic [DATA_W-1:0] lane_top_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int l = 0; l < LANES; l++) m[l*LANE_W + LANE_W-1] = 1'b1;
        return m;
    endfunction

    // Word with the value 1 in each lane.
    function automatic logic [DATA_W-1:0] lane_one_word();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int l = 0; l < LANES; l++) m[l*LANE_W] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/swar_lane_adder.sv
module swar_lane_adder
    import swar_alu_pkg::*;
(
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              packed_i,
    output logic [DATA_W-1:0] sum_o
);
    localparam logic [DATA_W-1:0] TOP_M = lane_top_mask();

    logic [DATA_W-1:0] keep_d;
    logic [DATA_W-1:0] raw_d;

    always_comb begin
        keep_d = packed_i ? ~TOP_M : '1;
        raw_d  = (x_i & keep_d) + (y_i & keep_d);
        sum_o  = raw_d ^ ((x_i ^ y_i) & ~keep_d);
    end

    // R3: every lane of the packed sum is an isolated 8-bit sum
    for (genvar l = 0; l < LANES; l++) begin : g_chk
        logic [LANE_W-1:0] lane_ref_d;
        always_comb begin
            lane_ref_d = x_i[l*LANE_W +: LANE_W] + y_i[l*LANE_W +: LANE_W];
            if (packed_i)
                a_r3_lane_isolated: assert (sum_o[l*LANE_W +: LANE_W] == lane_ref_d)
                    else $error("lane %0d carry leak", l);
        end
    end

endmodule

// File: rtl/swar_shifter.sv
module swar_shifter
    import swar_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [LANE_W-1:0] amt_i,
    output logic [DATA_W-1:0] res_o
);
    localparam int MAG_W = LANE_W + 1;

    logic [MAG_W-1:0] mag_d;
    logic             big_d;

    always_comb begin
        mag_d = amt_i[LANE_W-1] ? (MAG_W'(0) - {1'b1, amt_i}) : {1'b0, amt_i};
        big_d = mag_d >= MAG_W'(DATA_W);
        if (big_d)                 res_o = '0;
        else if (amt_i[LANE_W-1])  res_o = a_i >> mag_d;
        else                       res_o = a_i << mag_d;
    end

    // R7: a zero amount leaves the operand unchanged
    always_comb begin
        if (amt_i == '0)
            a_r7_zero_shift: assert (res_o == a_i) else $error("zero shift altered word");
    end

endmodule

// File: rtl/swar_lane_select.sv
module swar_lane_select
    import swar_alu_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [LIDX_W-1:0] lane_i,
    output logic [DATA_W-1:0] unpack_o,
    output logic [DATA_W-1:0] pack_o
);
    logic [LSEL_W-1:0] sel_d;
    logic [DATA_W-1:0] shifted_d;

    always_comb begin
        sel_d     = lane_i[LSEL_W-1:0];
        shifted_d = a_i >> (int'(sel_d) * LANE_W);
        unpack_o  = {{(DATA_W-LANE_W){1'b0}}, shifted_d[LANE_W-1:0]};
    end

    for (genvar l = 0; l < LANES; l++) begin : g_pack
        always_comb begin
            pack_o[l*LANE_W +: LANE_W] = (sel_d == LSEL_W'(l)) ? a_i[LANE_W-1:0]
                                                               : b_i[l*LANE_W +: LANE_W];
        end
        // R9: lanes not selected carry the destination byte through
        always_comb begin
            if (sel_d != LSEL_W'(l))
                a_r9_pack_keep: assert (pack_o[l*LANE_W +: LANE_W] == b_i[l*LANE_W +: LANE_W])
                    else $error("pack disturbed lane %0d", l);
        end
    end

    // R8: unpack leaves the upper bytes clear
    always_comb begin
        a_r8_unpack_zext: assert (unpack_o[DATA_W-1:LANE_W] == '0) else $error("unpack upper bits set");
    end

endmodule

// File: rtl/swar_alu.sv
module swar_alu
    import swar_alu_pkg::*;
(
    input  logic [3:0]  op_i,
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    input  logic [3:0]  lane_i,
    output logic [31:0] result_o
);
    localparam logic [DATA_W-1:0] ONE_LANES = lane_one_word();

    alu_op_e           op_d;
    logic              neg_d;
    logic              packed_d;
    logic [DATA_W-1:0] add_x_d;
    logic [DATA_W-1:0] add_y_d;
    logic [DATA_W-1:0] sum_d;
    logic [DATA_W-1:0] shift_d;
    logic [DATA_W-1:0] unpack_d;
    logic [DATA_W-1:0] pack_d;
    logic [DATA_W-1:0] anyv_d;
    logic [DATA_W-1:0] result_d;

    // Operand steering for the shared adder
    always_comb begin
        op_d     = alu_op_e'(op_i);
        neg_d    = (op_d == OP_NEG) || (op_d == OP_NEGV);
        packed_d = (op_d == OP_ADDV) || (op_d == OP_NEGV);
        add_x_d  = neg_d ? ~a_i : a_i;
        if (!neg_d)        add_y_d = b_i;
        else if (packed_d) add_y_d = ONE_LANES;
        else               add_y_d = DATA_W'(1);
    end

    swar_lane_adder u_adder (
        .x_i      (add_x_d),
        .y_i      (add_y_d),
        .packed_i (packed_d),
        .sum_o    (sum_d)
    );

    swar_shifter u_shift (
        .a_i   (a_i),
        .amt_i (b_i[LANE_W-1:0]),
        .res_o (shift_d)
    );

    swar_lane_select u_lsel (
        .a_i      (a_i),
        .b_i      (b_i),
        .lane_i   (lane_i),
        .unpack_o (unpack_d),
        .pack_o   (pack_d)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_anyv
        always_comb anyv_d[l*LANE_W +: LANE_W] = LANE_W'(|a_i[l*LANE_W +: LANE_W]);
    end

    always_comb begin
        case (op_d)
            OP_AND:    result_d = a_i & b_i;
            OP_OR:     result_d = a_i | b_i;
            OP_XOR:    result_d = a_i ^ b_i;
            OP_ADD,
            OP_ADDV,
            OP_NEG,
            OP_NEGV:   result_d = sum_d;
            OP_SHIFT:  result_d = shift_d;
            OP_PACK:   result_d = pack_d;
            OP_UNPACK: result_d = unpack_d;
            OP_ANY:    result_d = DATA_W'(|a_i);
            OP_ANYV:   result_d = anyv_d;
            default:   result_d = '0;
        endcase
        result_o = result_d;
    end

    // R4: a word negation added back to its operand cancels
    always_comb begin
        if (op_d == OP_NEG)
            a_r4_neg_cancels: assert (result_o + a_i == '0) else $error("negation does not cancel");
    end

    // R6: the word any result is boolean and tracks the operand
    always_comb begin
        if (op_d == OP_ANY)
            a_r6_any_bool: assert ((result_o[DATA_W-1:1] == '0) && (result_o[0] == (a_i != '0)))
                else $error("any result malformed");
    end

endmodule

// File: tb/sim_swar_alu.sv
module sim_swar_alu;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  lane;
    logic [31:0] res;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];

    always #10 clk = ~clk;

    swar_alu u0 (
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .lane_i   (lane),
        .result_o (res)
    );

    function automatic logic [31:0] ref_addv(logic [31:0] x, logic [31:0] y);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = x[l*8 +: 8] + y[l*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] ref_negv(logic [31:0] x);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = 8'd0 - x[l*8 +: 8];
        return r;
    endfunction

    function automatic logic [31:0] ref_anyv(logic [31:0] x);
        logic [31:0] r;
        for (int l = 0; l < 4; l++) r[l*8 +: 8] = (x[l*8 +: 8] != 8'd0) ? 8'h01 : 8'h00;
        return r;
    endfunction

    function automatic logic [31:0] ref_shift(logic [31:0] x, logic [31:0] y);
        int s;
        s = int'($signed(y[7:0]));
        if (s >= 32 || s <= -32) return 32'd0;
        if (s >= 0) return x << s;
        return x >> (-s);
    endfunction

    function automatic logic [31:0] ref_unpack(logic [31:0] x, logic [3:0] p);
        int k;
        k = int'(p) % 4;
        return {24'd0, x[k*8 +: 8]};
    endfunction

    function automatic logic [31:0] ref_pack(logic [31:0] x, logic [31:0] y, logic [3:0] p);
        logic [31:0] r;
        int k;
        k = int'(p) % 4;
        r = y;
        r[k*8 +: 8] = x[7:0];
        return r;
    endfunction

    task automatic drive(input logic [3:0] o, input logic [31:0] x, input logic [31:0] y,
                         input logic [3:0] p, input logic [31:0] e, input string tag);
        item_t it;
        @(posedge clk);
        #2;
        op = o; a = x; b = y; lane = p;
        it.exp = e;
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: compares one queued expectation per cycle at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                total++;
                if (res !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got %08h expected %08h", it.tag, res, it.exp);
                end
            end
        end
    end

    initial begin
        op = 4'd0; a = '0; b = '0; lane = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        drive(4'd0, 32'h0, 32'h0, 4'd0, 32'h0, "R1 reset-state and of zeros");
        drive(4'd0, 32'hF0F0_1234, 32'hFF00_FF0F, 4'd0, 32'hF0F0_1234 & 32'hFF00_FF0F, "R1 and");
        drive(4'd1, 32'hF0F0_1234, 32'h0F00_00C3, 4'd0, 32'hF0F0_1234 | 32'h0F00_00C3, "R1 or");
        drive(4'd2, 32'hAAAA_5555, 32'hFFFF_0000, 4'd0, 32'hAAAA_5555 ^ 32'hFFFF_0000, "R1 xor");
        drive(4'd4, 32'hFFFF_FFFF, 32'h0101_0101, 4'd0, 32'h0101_0100, "R2 word add carries");
        drive(4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 4'd0, 32'h0000_0000, "R2 carry out dropped");
        drive(4'd5, 32'hFFFF_FFFF, 32'h0101_0101, 4'd0, ref_addv(32'hFFFF_FFFF, 32'h0101_0101), "R3 ff lanes plus 01");
        drive(4'd5, 32'h7F80_FF01, 32'h0180_7F01, 4'd0, ref_addv(32'h7F80_FF01, 32'h0180_7F01), "R3 mixed lanes");
        drive(4'd5, 32'h8080_8080, 32'h8080_8080, 4'd0, ref_addv(32'h8080_8080, 32'h8080_8080), "R3 top bits only");
        drive(4'd5, 32'h1234_5678, 32'h0FED_CBA9, 4'd0, ref_addv(32'h1234_5678, 32'h0FED_CBA9), "R3 general");
        drive(4'd12, 32'h0000_0001, 32'h0, 4'd0, 32'hFFFF_FFFF, "R4 neg one");
        drive(4'd12, 32'h0000_0000, 32'h0, 4'd0, 32'h0000_0000, "R4 neg zero");
        drive(4'd12, 32'h8000_0000, 32'h0, 4'd0, 32'h8000_0000, "R4 neg min");
        drive(4'd13, 32'h0001_80FF, 32'h0, 4'd0, ref_negv(32'h0001_80FF), "R5 lane neg");
        drive(4'd13, 32'h0000_0000, 32'h0, 4'd0, 32'h0000_0000, "R5 lane neg zero");
        drive(4'd10, 32'h0010_0000, 32'h0, 4'd0, 32'h1, "R6 any set");
        drive(4'd10, 32'h0, 32'hFFFF_FFFF, 4'd0, 32'h0, "R6 any clear");
        drive(4'd11, 32'h00FF_0080, 32'h0, 4'd0, ref_anyv(32'h00FF_0080), "R6 anyv");
        drive(4'd7, 32'h8000_0001, 32'hFFFF_FF04, 4'd0, ref_shift(32'h8000_0001, 32'h04), "R7 left 4 upper b ignored");
        drive(4'd7, 32'h8000_0001, 32'h0000_00FC, 4'd0, ref_shift(32'h8000_0001, 32'hFC), "R7 right 4 logical");
        drive(4'd7, 32'hDEAD_BEEF, 32'h0000_001F, 4'd0, 32'h8000_0000, "R7 left 31");
        drive(4'd7, 32'hDEAD_BEEF, 32'h0000_0020, 4'd0, 32'h0, "R7 left 32");
        drive(4'd7, 32'hDEAD_BEEF, 32'h0000_00E0, 4'd0, 32'h0, "R7 right 32");
        drive(4'd7, 32'hDEAD_BEEF, 32'h0000_0080, 4'd0, 32'h0, "R7 minus 128");
        drive(4'd7, 32'hDEAD_BEEF, 32'h0000_00E1, 4'd0, 32'h0000_0001, "R7 right 31");
        drive(4'd7, 32'hDEAD_BEEF, 32'h1234_5600, 4'd0, 32'hDEAD_BEEF, "R7 zero amount");
        for (int p = 0; p < 16; p += 5) begin
            drive(4'd9, 32'hA1B2_C3D4, 32'h0, 4'(p), ref_unpack(32'hA1B2_C3D4, 4'(p)), "R8 unpack");
            drive(4'd8, 32'h0000_005A, 32'h1122_3344, 4'(p), ref_pack(32'h5A, 32'h1122_3344, 4'(p)), "R9 pack");
        end
        drive(4'd9, 32'hA1B2_C3D4, 32'h0, 4'd3, 32'h0000_00A1, "R8 unpack lane 3");
        drive(4'd8, 32'hFFFF_FF5A, 32'h1122_3344, 4'd6, 32'h115A_3344, "R9 pack idx 6");
        drive(4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd0, 32'h0, "R10 code 3");
        drive(4'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd0, 32'h0, "R10 code 6");
        drive(4'd14, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd0, 32'h0, "R10 code 14");
        drive(4'd15, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd0, 32'h0, "R10 code 15");
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule